// File: doc/BRIEF.md
# Multiplexed ADC Channel Sequencer

This block decides which of sixteen analog inputs a successive-approximation converter samples on each serial transfer, and it formats each finished result into a tagged 16-bit word. Every transfer brings in one 16-bit input word on `din_i`, marked by a one-cycle `xfer_i` strobe. That word is either a control word or, right after a shadow-load request, a channel mask.

The block drives `chan_o`, the channel that the next transfer converts. When a transfer strobes, that channel is latched as the channel of the conversion now under way. When the converter returns its 12-bit raw value on `raw_vld_i`, the block emits the channel tag and the coded result one cycle later.

Three selection behaviours exist:
- **Single channel:** the same addressed channel is converted on every transfer.
- **Mask sequence:** the block walks upward through the set bits of a 16-bit mask and wraps back to the lowest set bit.
- **Run sequence:** the block counts from channel 0 up to the addressed channel and restarts at 0.

Control word fields are bit 15 write, bit 14 seq, bit 13 shadow, bits 12:9 address and bit 8 range. Bits 7:0 are ignored.

Top module: `adc_chan_seq`

## Requirements
- R1: After reset, `chan_o` is 0 in single-channel mode, `word_vld_o` is 0, and the range bit is 0 (straight binary).
- R2: A transfer with bit15=1, bit14=0, bit13=0 selects single mode with address bits 12:9. From the edge of that transfer on, `chan_o` equals that address and stays there on later transfers.
- R3: A transfer with bit15=1, bit14=0, bit13=1 makes the next transfer's 16 data bits load the mask, not a control word. After that load, `chan_o` is the lowest set bit of the mask.
- R4: In mask mode, each transfer moves `chan_o` to the next higher set mask bit. After the highest set bit it wraps to the lowest set bit.
- R5: A mask of all zeros makes `chan_o` 0 on every transfer.
- R6: A transfer with bit15=0 changes no configuration, and the current selection advances as its mode dictates.
- R7: A write with bit14=1, bit13=0 keeps the mode, the address and the sequence position unchanged. It only updates the range bit.
- R8: A write with bit14=1, bit13=1 starts the run sequence. `chan_o` goes to 0, then steps by one per transfer up to the address in bits 12:9, then returns to 0.
- R9: One cycle after `raw_vld_i`, `word_vld_o` pulses. `word_o[15:12]` holds the channel that was on `chan_o` at the strobe of the transfer that started that conversion, and `word_o[11:0]` holds the coded result.
- R10: With range bit 0, the result field equals `raw_i`. With range bit 1 it is twos complement, which is `raw_i` with bit 11 inverted.
- R11: A write with any seq/shadow pair other than 1,0 ends a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xfer_i | input | 1 | One-cycle strobe per serial transfer |
| din_i | input | 16 | Word received during the transfer |
| raw_vld_i | input | 1 | Raw conversion result valid |
| raw_i | input | 12 | Raw straight-binary conversion value |
| chan_o | output | 4 | Channel converted by the next transfer |
| word_vld_o | output | 1 | Formatted result valid |
| word_o | output | 16 | Channel tag and coded result |

## Verification
`chan_o` takes its new value at the clock edge that samples `xfer_i`. The bench therefore drives the strobe on a falling edge and compares `chan_o` with its model on the next falling edge. The formatted word is registered once behind `raw_vld_i`, so it is checked on the falling edge right after the strobe edge. One more falling edge later, the bench confirms that `word_vld_o` has dropped. Mode changes take effect on the same edge as the transfer that carries them, while the channel tag of a conversion comes from the value held before that edge. The model follows both rules.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W      = 4;
  localparam int NCH       = 1 << CH_W;
  localparam int RAW_W     = 12;
  localparam int WORD_W    = CH_W + RAW_W;
  localparam int WR_BIT    = 15;
  localparam int SEQ_BIT   = 14;
  localparam int SHD_BIT   = 13;
  localparam int ADDR_LSB  = 9;
  localparam int RANGE_BIT = 8;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MASK   = 2'd1,
    MODE_RUN    = 2'd2
  } mode_e;
endpackage

// File: rtl/adc_seq_next.sv
module adc_seq_next #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [CW-1:0]  cur_i,
  output logic [CW-1:0]  first_o,
  output logic [CW-1:0]  next_o
);
  logic [NCH-1:0] above;
  logic [CW-1:0]  up;

  for (genvar i = 0; i < NCH; i++) begin : g_above
    assign above[i] = mask_i[i] && (i > int'(cur_i));
  end

  // scan high to low so the lowest hit wins
  always_comb begin
    first_o = '0;
    up      = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) first_o = CW'(i);
      if (above[i])  up      = CW'(i);
    end
    next_o = (|above) ? up : first_o;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           xfer_i,
  input  logic [DW-1:0]  din_i,
  output logic [CW-1:0]  cur_o,
  output logic [CW-1:0]  conv_o,
  output logic           rng_o,
  output mode_e          mode_o,
  output logic [CW-1:0]  addr_o,
  output logic [NCH-1:0] mask_o
);
  mode_e          mode_q, mode_d;
  logic [CW-1:0]  addr_q, addr_d, cur_q, cur_d, conv_q;
  logic [NCH-1:0] mask_q, mask_d, mask_sel;
  logic           rng_q, rng_d, ld_q, ld_d;
  logic [CW-1:0]  first, nxt;

  logic          wr, seq, shd, rng_in;
  logic [CW-1:0] addr_in;
  assign wr      = din_i[WR_BIT];
  assign seq     = din_i[SEQ_BIT];
  assign shd     = din_i[SHD_BIT];
  assign rng_in  = din_i[RANGE_BIT];
  assign addr_in = din_i[ADDR_LSB +: CW];

  // one finder serves both the stored mask and a mask being loaded
  assign mask_sel = ld_q ? din_i[NCH-1:0] : mask_q;

  adc_seq_next #(.NCH(NCH)) u_next (
    .mask_i (mask_sel),
    .cur_i  (cur_q),
    .first_o(first),
    .next_o (nxt)
  );

  always_comb begin
    mode_d = mode_q;
    addr_d = addr_q;
    rng_d  = rng_q;
    mask_d = mask_q;
    ld_d   = ld_q;
    cur_d  = cur_q;
    if (xfer_i) begin
      if (ld_q) begin
        mask_d = din_i[NCH-1:0];
        ld_d   = 1'b0;
        mode_d = MODE_MASK;
        cur_d  = first;
      end else if (wr && !(seq && !shd)) begin
        addr_d = addr_in;
        rng_d  = rng_in;
        if (seq) begin
          mode_d = MODE_RUN;
          cur_d  = '0;
        end else begin
          mode_d = MODE_SINGLE;
          ld_d   = shd;
          cur_d  = addr_in;
        end
      end else begin
        if (wr) rng_d = rng_in;
        unique case (mode_q)
          MODE_MASK: cur_d = nxt;
          MODE_RUN:  cur_d = (cur_q == addr_q) ? '0 : cur_q + 1'b1;
          default:   cur_d = addr_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SINGLE;
      addr_q <= '0;
      rng_q  <= 1'b0;
      mask_q <= '0;
      ld_q   <= 1'b0;
      cur_q  <= '0;
      conv_q <= '0;
    end else begin
      mode_q <= mode_d;
      addr_q <= addr_d;
      rng_q  <= rng_d;
      mask_q <= mask_d;
      ld_q   <= ld_d;
      cur_q  <= cur_d;
      if (xfer_i) conv_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign conv_o = conv_q;
  assign rng_o  = rng_q;
  assign mode_o = mode_q;
  assign addr_o = addr_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
  parameter int CW    = 4,
  parameter int RAW_W = 12,
  localparam int WW   = CW + RAW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [RAW_W-1:0] raw_i,
  input  logic [CW-1:0]    chan_i,
  input  logic             rng_i,
  output logic             vld_o,
  output logic [WW-1:0]    word_o
);
  logic [RAW_W-1:0] coded;

  // offset binary to twos complement: flip the sign position
  assign coded = rng_i ? {~raw_i[RAW_W-1], raw_i[RAW_W-2:0]} : raw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      word_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) word_o <= {chan_i, coded};
    end
  end
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              raw_vld_i,
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CH_W-1:0]   chan_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  logic [CH_W-1:0] conv_chan, addr_q;
  logic [NCH-1:0]  mask_q;
  logic            rng;
  mode_e           mode_q;

  adc_seq_ctrl #(.NCH(NCH), .DW(WORD_W)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .xfer_i(xfer_i),
    .din_i (din_i),
    .cur_o (chan_o),
    .conv_o(conv_chan),
    .rng_o (rng),
    .mode_o(mode_q),
    .addr_o(addr_q),
    .mask_o(mask_q)
  );

  adc_seq_fmt #(.CW(CH_W), .RAW_W(RAW_W)) u_fmt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (raw_vld_i),
    .raw_i (raw_i),
    .chan_i(conv_chan),
    .rng_i (rng),
    .vld_o (word_vld_o),
    .word_o(word_o)
  );
endmodule

// File: rtl/adc_chan_seq_chk.sv
module adc_chan_seq_chk
  import adc_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_i,
  input logic              raw_vld_i,
  input logic [RAW_W-1:0]  raw_i,
  input logic [CH_W-1:0]   chan_o,
  input logic              word_vld_o,
  input logic [WORD_W-1:0] word_o,
  input mode_e             mode_q,
  input logic [CH_W-1:0]   addr_q,
  input logic [NCH-1:0]    mask_q
);
  // R9: result valid follows raw valid by one cycle
  a_r9_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_vld_i |=> word_vld_o);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_vld_i |=> !word_vld_o);
  // R10: coding never touches the low bits
  a_r10_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_vld_i |=> word_o[RAW_W-2:0] == $past(raw_i[RAW_W-2:0]));
  // R6: selection only moves on a transfer
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(chan_o));
  // R8: run sequence never passes its end channel
  a_r8_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_RUN |-> chan_o <= addr_q);
  // R4: mask sequence only visits selected channels
  a_r4_mask_member: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_MASK && mask_q != '0) |-> mask_q[chan_o]);
  // R5: empty mask parks on channel 0
  a_r5_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_MASK && mask_q == '0) |-> chan_o == '0);
endmodule

bind adc_chan_seq adc_chan_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .xfer_i    (xfer_i),
  .raw_vld_i (raw_vld_i),
  .raw_i     (raw_i),
  .chan_o    (chan_o),
  .word_vld_o(word_vld_o),
  .word_o    (word_o),
  .mode_q    (mode_q),
  .addr_q    (addr_q),
  .mask_q    (mask_q)
);

// File: tb/adc_chan_seq_tb.sv
`timescale 1ns/1ps
module adc_chan_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_i = 1'b0;
  logic [15:0] din_i = '0;
  logic        raw_vld_i = 1'b0;
  logic [11:0] raw_i = '0;
  logic [3:0]  chan_o;
  logic        word_vld_o;
  logic [15:0] word_o;

  int nchk = 0;
  int nfail = 0;

  // model state: mode 0 single, 1 mask, 2 run
  int        m_mode = 0;
  logic [3:0]  m_addr = '0, m_cur = '0, m_conv = '0;
  logic [15:0] m_mask = '0;
  logic        m_rng = 1'b0, m_ld = 1'b0;

  always #10 clk_i = ~clk_i;

  adc_chan_seq u_dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input bit wr, input bit seq, input bit shd,
                                      input logic [3:0] a, input bit rng);
    return {wr, seq, shd, a, rng, 8'h00};
  endfunction

  function automatic logic [3:0] lowest(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return 4'(i);
    return 4'd0;
  endfunction

  function automatic logic [3:0] succ(input logic [15:0] m, input logic [3:0] c);
    for (int i = 0; i < 16; i++) if (m[i] && i > int'(c)) return 4'(i);
    return lowest(m);
  endfunction

  task automatic model_xfer(input logic [15:0] d);
    m_conv = m_cur;
    if (m_ld) begin
      m_mask = d; m_ld = 1'b0; m_mode = 1; m_cur = lowest(d);
    end else if (d[15] && !(d[14] && !d[13])) begin
      m_addr = d[12:9]; m_rng = d[8];
      if (d[14]) begin m_mode = 2; m_cur = 4'd0; end
      else begin m_mode = 0; m_ld = d[13]; m_cur = d[12:9]; end
    end else begin
      if (d[15]) m_rng = d[8];
      case (m_mode)
        1: m_cur = succ(m_mask, m_cur);
        2: m_cur = (m_cur == m_addr) ? 4'd0 : m_cur + 4'd1;
        default: m_cur = m_addr;
      endcase
    end
  endtask

  task automatic do_xfer(input logic [15:0] d, input string tag);
    @(negedge clk_i);
    xfer_i = 1'b1; din_i = d;
    @(posedge clk_i);
    model_xfer(d);
    @(negedge clk_i);
    xfer_i = 1'b0; din_i = '0;
    chk(tag, 16'(chan_o), 16'(m_cur));
  endtask

  task automatic do_res(input logic [11:0] r, input string tag);
    logic [11:0] c;
    c = m_rng ? {~r[11], r[10:0]} : r;
    raw_vld_i = 1'b1; raw_i = r;
    @(negedge clk_i);
    raw_vld_i = 1'b0;
    chk({tag, " vld"}, 16'(word_vld_o), 16'd1);
    chk({tag, " word"}, word_o, {m_conv, c});
    @(negedge clk_i);
    chk({tag, " vld drop"}, 16'(word_vld_o), 16'd0);
  endtask

  task automatic step(input logic [15:0] d, input string tag);
    do_xfer(d, tag);
    do_res(12'($urandom), "R9 R10 result");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 chan reset", 16'(chan_o), 16'd0);
    chk("R1 vld reset", 16'(word_vld_o), 16'd0);
    step(16'h0000, "R1 first xfer");
    do_xfer(16'h0000, "R1 idle xfer");
    do_res(12'h800, "R1 straight coding");
    // single channel
    step(ctl(1, 0, 0, 4'd5, 0), "R2 single write");
    step(16'h0000, "R2 single hold");
    step(16'h0000, "R2 single hold");
    // mask load and walk
    step(ctl(1, 0, 1, 4'd2, 0), "R3 shadow req");
    step(16'h8421, "R3 mask load");
    for (int i = 0; i < 6; i++) step(16'h0000, "R4 mask walk");
    // keep-running write with range change
    step(ctl(1, 1, 0, 4'd9, 1), "R7 keep running");
    step(16'h0000, "R7 continue");
    do_xfer(16'h0000, "R10 twos");
    do_res(12'h000, "R10 twos min");
    do_xfer(16'h0000, "R10 twos");
    do_res(12'hFFF, "R10 twos max");
    // run sequence ends mask
    step(ctl(1, 1, 1, 4'd3, 0), "R11 run start");
    for (int i = 0; i < 6; i++) step(16'h0000, "R8 run walk");
    step(ctl(1, 1, 1, 4'd0, 0), "R8 run to zero");
    step(16'h0000, "R8 run zero");
    step(ctl(1, 1, 1, 4'd15, 0), "R8 run full");
    for (int i = 0; i < 17; i++) step(16'h0000, "R8 run wrap");
    // empty mask
    step(ctl(1, 0, 1, 4'd7, 0), "R3 shadow req");
    step(16'h0000, "R5 empty mask");
    for (int i = 0; i < 3; i++) step(16'h0000, "R5 stays zero");
    step(ctl(1, 0, 1, 4'd7, 0), "R3 shadow req");
    step(16'h8000, "R4 single bit mask");
    step(16'h0000, "R4 single bit wrap");
    step(ctl(1, 0, 0, 4'd11, 1), "R11 single ends mask");
    step(16'h0000, "R6 no write");
    // random mix
    for (int i = 0; i < 500; i++) begin
      d = 16'($urandom);
      if ($urandom % 3 != 0) d[15] = 1'b0;
      if (d[15] && ($urandom % 2 == 0)) begin d[14] = 1'b1; d[13] = 1'b0; end
      step(d, "R6 R7 R11 random");
    end
    summary();
  end
endmodule